// File: doc/BRIEF.md
# Packet Framer and Link Serializer

This block turns one transaction descriptor into a packet of 32-bit words and sends that packet over a narrow unidirectional link. A descriptor carries a command code, an address, a flag that selects wide (64-bit) addressing, and a payload length in bytes. The block builds the control words from these fields. When the long-address flag is set, it puts one extension word in front of the control words. It then fetches the payload words from a word stream and zeroes the unused bytes of a partial last word.

Each 32-bit word is cut into bit times that match a link width chosen at run time: 2, 4, 8, 16 or 32 lanes. One bit time goes out per cycle of the double-rate link clock, low-order bits first. A framing strobe marks which bit times belong to control words. The width is captured when a descriptor is accepted, so a packet never changes width partway through.

Top module: `pkt_link_tx`

## Requirements
- R1: While reset is held and right after it, `link_valid`, `link_ctl`, `link_data` and `pl_rd` are 0 and `desc_ready` is 1.
- R2: `width_sel` codes 0, 1, 2, 3 and 4 select 2, 4, 8, 16 and 32 lanes. Each word takes 32/width bit times. Bit time k carries word bits [k*width+width-1 : k*width] on `link_data[width-1:0]`, and every lane above the width reads 0.
- R3: The first control word is {addr[15:0], 2'b00, payload word count (8 bits), cmd[5:0]}, so the command sits in bits 5:0.
- R4: The second control word is {8'h00, addr[39:16]}.
- R5: With `desc_long` set, an extension word {addr[63:40], 2'b00, 6'h3E} goes out ahead of the two control words. Its bits 5:0 hold the extension code 6'h3E.
- R6: The payload is ceil(len/4) words, sent only after the last control word. For each word `pl_rd` pulses once, and the word is taken from `pl_data` in the cycle the pulse is high. A length of 0 sends no payload and never raises `pl_rd`.
- R7: When len mod 4 is nonzero, the bytes of the last payload word at and above byte index len mod 4 are sent as 0.
- R8: `link_ctl` is 1 for every bit time of an extension or control word and 0 for every payload bit time.
- R9: A descriptor is accepted on a clock edge where `desc_valid` and `desc_ready` are both 1. Its first bit time appears in the next cycle, and the bit times follow with no gap. `desc_ready` stays 0 until the last bit time has been sent and returns to 1 in the cycle after it.
- R10: `width_sel` is sampled only when a descriptor is accepted. A change of `width_sel` during a packet has no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate link clock, one bit time per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| width_sel | input | 3 | Link width code, sampled when a descriptor is accepted |
| desc_valid | input | 1 | Descriptor present |
| desc_ready | output | 1 | Block can accept a descriptor |
| desc_cmd | input | 6 | Command code |
| desc_addr | input | 64 | Request address |
| desc_long | input | 1 | Send the extension word for 64-bit addressing |
| desc_len | input | LEN_W | Payload length in bytes |
| pl_rd | output | 1 | Payload word taken from pl_data this cycle |
| pl_data | input | 32 | Next payload word |
| link_valid | output | 1 | A bit time is on the link |
| link_ctl | output | 1 | Bit time belongs to a control or extension word |
| link_data | output | 32 | Link lanes, the low `width` lanes in use |

## Verification
The bench sends packets at every one of the five widths. For each width it tries both address modes and a set of payload lengths: empty, a single byte, exact multiples of four, and each nonzero remainder. These lengths separate a missing or extra payload word, the byte mask on a partial last word, and the position of the extension word in front of the control words. One maximum-length packet on the narrowest link exercises the payload counter at its limit. Some packets change `width_sel` after their first bit time, which shows that the captured width is the one used. Each word is rebuilt lane by lane from the link, and its strobe and idle lanes are checked against values the bench computes itself.

// File: rtl/pkt_link_tx.sv
module pkt_link_tx #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       width_sel,
  input  logic             desc_valid,
  output logic             desc_ready,
  input  logic [5:0]       desc_cmd,
  input  logic [63:0]      desc_addr,
  input  logic             desc_long,
  input  logic [LEN_W-1:0] desc_len,
  output logic             pl_rd,
  input  logic [31:0]      pl_data,
  output logic             link_valid,
  output logic             link_ctl,
  output logic [31:0]      link_data
);
  localparam int NW_W = LEN_W;
  localparam logic [5:0] EXT_CODE = 6'h3E;

  typedef enum logic [2:0] {S_IDLE, S_EXT, S_CTL0, S_CTL1, S_PAY} st_t;

  st_t            st;
  logic [31:0]    sh;
  logic [5:0]     bt;
  logic [2:0]     wlog_q;
  logic [5:0]     cmd_q;
  logic [63:0]    addr_q;
  logic [NW_W-1:0] nw_q, left_q;
  logic [1:0]     tail_q;

  logic [2:0]     wlog_in;
  logic [NW_W-1:0] nw_in;
  logic [5:0]     beats;
  logic           last_bt, accept, load_first, load_next;
  logic [NW_W-1:0] new_left;
  logic [31:0]    tail_mask, pay_word, lane_mask, w_ctl0, w_ctl1;

  assign wlog_in  = (width_sel > 3'd4) ? 3'd5 : width_sel + 3'd1;
  assign nw_in    = NW_W'(({1'b0, desc_len} + (LEN_W+1)'(3)) >> 2);
  assign beats    = 6'd32 >> wlog_q;
  assign last_bt  = (bt == beats - 6'd1);
  assign accept   = desc_valid && desc_ready;

  assign w_ctl0   = {addr_q[15:0], 2'b00, 8'(nw_q), cmd_q};
  assign w_ctl1   = {8'h00, addr_q[39:16]};

  assign load_first = (st == S_CTL1) && last_bt && (nw_q != '0);
  assign load_next  = (st == S_PAY) && last_bt && (left_q > NW_W'(1));
  assign new_left   = load_first ? nw_q : left_q - NW_W'(1);
  assign tail_mask  = (tail_q == 2'd0) ? 32'hFFFF_FFFF
                                       : (32'd1 << (6'd8 * 6'(tail_q))) - 32'd1;
  assign pay_word   = (new_left == NW_W'(1)) ? (pl_data & tail_mask) : pl_data;

  assign lane_mask  = (wlog_q >= 3'd5) ? 32'hFFFF_FFFF
                                       : (32'd1 << (6'd1 << wlog_q)) - 32'd1;

  assign pl_rd      = load_first || load_next;
  assign desc_ready = (st == S_IDLE);
  assign link_valid = (st != S_IDLE);
  assign link_ctl   = link_valid && (st != S_PAY);
  assign link_data  = link_valid ? (sh & lane_mask) : 32'd0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      sh     <= '0;
      bt     <= '0;
      wlog_q <= 3'd1;
      cmd_q  <= '0;
      addr_q <= '0;
      nw_q   <= '0;
      left_q <= '0;
      tail_q <= '0;
    end else if (st == S_IDLE) begin
      if (accept) begin
        wlog_q <= wlog_in;
        cmd_q  <= desc_cmd;
        addr_q <= desc_addr;
        nw_q   <= nw_in;
        tail_q <= desc_len[1:0];
        bt     <= '0;
        if (desc_long) begin
          sh <= {desc_addr[63:40], 2'b00, EXT_CODE};
          st <= S_EXT;
        end else begin
          sh <= {desc_addr[15:0], 2'b00, 8'(nw_in), desc_cmd};
          st <= S_CTL0;
        end
      end
    end else if (!last_bt) begin
      sh <= sh >> (6'd1 << wlog_q);
      bt <= bt + 6'd1;
    end else begin
      bt <= '0;
      case (st)
        S_EXT:  begin sh <= w_ctl0; st <= S_CTL0; end
        S_CTL0: begin sh <= w_ctl1; st <= S_CTL1; end
        S_CTL1: begin
          if (load_first) begin
            sh <= pay_word; left_q <= new_left; st <= S_PAY;
          end else st <= S_IDLE;
        end
        default: begin
          if (load_next) begin
            sh <= pay_word; left_q <= new_left;
          end else st <= S_IDLE;
        end
      endcase
    end
  end

  // R9
  accept_starts_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && desc_ready) |=> (link_valid && link_ctl && !desc_ready));

  // R6
  payload_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_rd |=> (link_valid && !link_ctl));

  // R8
  ctl_before_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && $past(link_valid)) |-> !$rose(link_ctl));

  // R9
  ready_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_valid) |-> desc_ready);

  // R10
  width_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && $past(link_valid)) |-> $stable(wlog_q));

  // R2
  idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_valid |-> (link_data == 32'd0 && !link_ctl));
endmodule

// File: tb/tb_pkt_link_tx.sv
`timescale 1ns/1ps
module tb_pkt_link_tx;
  localparam int LEN_W = 8;

  logic clk = 0, rst_n = 0;
  logic [2:0] width_sel = 0;
  logic desc_valid = 0, desc_long = 0;
  logic [5:0] desc_cmd = 0;
  logic [63:0] desc_addr = 0;
  logic [LEN_W-1:0] desc_len = 0;
  logic desc_ready, pl_rd, link_valid, link_ctl;
  logic [31:0] pl_data, link_data;
  int pl_idx = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  pkt_link_tx #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel),
    .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_cmd(desc_cmd), .desc_addr(desc_addr), .desc_long(desc_long),
    .desc_len(desc_len), .pl_rd(pl_rd), .pl_data(pl_data),
    .link_valid(link_valid), .link_ctl(link_ctl), .link_data(link_data));

  function automatic logic [31:0] pay_fn(int i);
    return (32'h9E37_79B9 * 32'(i + 1)) ^ (32'(i) << 20);
  endfunction

  assign pl_data = pay_fn(pl_idx);
  always_ff @(posedge clk) if (pl_rd) pl_idx <= pl_idx + 1;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_pkt(int wsel, bit lng, logic [5:0] cmd,
                         logic [63:0] addr, int len, bit wiggle);
    logic [31:0] ew [0:80];
    bit ec [0:80];
    int n = 0;
    int nw = (len + 3) / 4;
    int base = pl_idx;
    int w = 2 << wsel;
    int beats = 32 / w;
    logic [31:0] lmask = (w == 32) ? 32'hFFFF_FFFF : (32'd1 << w) - 32'd1;
    if (lng) begin ew[n] = {addr[63:40], 2'b00, 6'h3E}; ec[n] = 1; n++; end
    ew[n] = {addr[15:0], 2'b00, 8'(nw), cmd}; ec[n] = 1; n++;
    ew[n] = {8'h00, addr[39:16]}; ec[n] = 1; n++;
    for (int j = 0; j < nw; j++) begin
      logic [31:0] pw = pay_fn(base + j);
      if (j == nw - 1 && (len % 4) != 0)
        pw = pw & ((32'd1 << (8 * (len % 4))) - 32'd1);
      ew[n] = pw; ec[n] = 0; n++;
    end
    width_sel  = 3'(wsel);
    desc_valid = 1; desc_long = lng; desc_cmd = cmd;
    desc_addr  = addr; desc_len = LEN_W'(len);
    @(posedge clk);
    @(negedge clk);
    desc_valid = 0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] acc = 0;
      bit frame_ok = 1;
      for (int b = 0; b < beats; b++) begin
        if (!link_valid || link_ctl != ec[i] || desc_ready ||
            (link_data & ~lmask) != 0) frame_ok = 0;
        acc = acc | ((link_data & lmask) << (b * w));
        if (wiggle && i == 0 && b == 0) width_sel = 3'((wsel + 2) % 5);
        @(negedge clk);
      end
      // R8 R9 R2 framing per word
      chk(frame_ok, "R8/R9/R2 framing", {63'd0, frame_ok}, 64'd1);
      if (lng && i == 0) chk(acc == ew[i], "R5 extension word", acc, ew[i]);
      else if (!ec[i] && i == n - 1 && (len % 4) != 0)
        chk(acc == ew[i], "R7 padded last word", acc, ew[i]);
      else if (!ec[i]) chk(acc == ew[i], "R6 payload word", acc, ew[i]);
      else if (i == n - nw - 2) chk(acc == ew[i], "R3 control word 0", acc, ew[i]);
      else chk(acc == ew[i], "R4 control word 1", acc, ew[i]);
      if (wiggle && i == 0)
        chk(acc == ew[i], "R10 width change ignored", acc, ew[i]);
    end
    // R9 end of packet
    chk(!link_valid && desc_ready, "R9 ready after last bit time",
        {62'd0, link_valid, desc_ready}, 64'd1);
    // R6 payload word count
    chk(pl_idx == base + nw, "R6 payload reads", 64'(pl_idx - base), 64'(nw));
    width_sel = 3'(wsel);
  endtask

  initial begin
    #800000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lens [8] = '{0, 1, 4, 5, 6, 7, 8, 13};
    int k = 0;
    repeat (3) @(negedge clk);
    // R1
    chk(!link_valid && !link_ctl && link_data == 0 && !pl_rd && desc_ready,
        "R1 reset state", {link_valid, link_ctl, pl_rd, desc_ready}, 64'h1);
    rst_n = 1;
    @(negedge clk);
    chk(!link_valid && desc_ready, "R1 after reset", {link_valid, desc_ready}, 64'h1);
    for (int ws = 0; ws < 5; ws++)
      for (int lg = 0; lg < 2; lg++)
        for (int li = 0; li < 8; li++) begin
          run_pkt(ws, lg[0], 6'(k * 7 + 3),
                  {32'hFEDC_BA98 ^ 32'(k * 977), 32'h7654_3210 + 32'(k * 40503)},
                  lens[li], lens[li] == 5);
          k++;
        end
    run_pkt(0, 1, 6'h15, 64'h0123_4567_89AB_CDEF, 255, 1);
    run_pkt(4, 0, 6'h2A, 64'hAAAA_5555_3C3C_C3C3, 255, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule